// File: doc/BRIEF.md
# Boundary-Aware Four-Neighbour Stencil Tuple Assembler

This block sits between a row-major grid stream and a point-wise compute kernel. For every grid point it presents the four direct neighbours (above, below, left, right), a validity mask and a code for which of nine edge or corner situations the point is in. Each grid value enters the block once per pass. Neighbours close in the stream come from a sliding window of two rows. Neighbours that wrap vertically (the row above row 0 is the last row, and the row below the last row is row 0) come from two static row caches instead. The left and right edges do not wrap: a missing horizontal neighbour is presented as zero with its mask bit cleared.

Three state machines run side by side. A prefetch machine consumes one warm-up pass to load the top and bottom rows into the active cache bank. A gather machine accepts the stream, emits one tuple per point and drains the last row after the stream ends. A write-back machine captures the kernel's results for the top and bottom rows into the shadow bank. When both the gather and write-back machines have finished a pass, the banks swap and the next pass, whose stream is the previous pass's results, is allowed in.

Top module: `stencil_tuple_asm`

## Requirements
- R1: After reset no tuple is offered (`outValid` low) and the block is ready for input (`inReady` high).
- R2: The first ROWS×COLS accepted input values form a warm-up pass that emits no tuple and whose row 0 and last row become the static rows for the first computed pass.
- R3: In each computed pass exactly ROWS×COLS tuples are emitted, one per grid point, in row-major order of their centre point, none dropped or repeated under any pattern of input and output stalls.
- R4: For a centre not in row 0, `nbUp` is the value one row above. For a centre not in the last row, `nbDown` is the value one row below.
- R5: For a centre in row 0, `nbUp` is the same column of the last row of the current pass's grid.
- R6: For a centre in the last row, `nbDown` is the same column of row 0 of the current pass's grid.
- R7: `nbMask` bit 0 marks up, bit 1 down, bit 2 left and bit 3 right. Bits 0 and 1 are always set. For column 0, bit 2 is clear and `nbLeft` is 0. For the last column, bit 3 is clear and `nbRight` is 0. Otherwise `nbLeft` and `nbRight` are the horizontal neighbours.
- R8: `pointCase` is 0 for an interior point, 1 top edge, 2 bottom edge, 3 left edge, 4 right edge, 5 top-left, 6 top-right, 7 bottom-left, 8 bottom-right.
- R9: While `outValid` is high and `outReady` low, `inReady` is low. If the source keeps `inValid` high, the same tuple is still offered in the next cycle.
- R10: Results returned on `resData` for rows 0 and ROWS-1 of a pass become the static rows of the next pass, and they do not disturb the tuples of the pass in progress.
- R11: Input for the next pass is not accepted until every result of the current pass has been returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Input stream value present |
| inData | input | DW | Input stream grid value, row-major |
| inReady | output | 1 | Block accepts the input value this cycle |
| outValid | output | 1 | Tuple offered |
| outReady | input | 1 | Kernel takes the tuple |
| nbUp | output | DW | Neighbour above (wraps at row 0) |
| nbDown | output | DW | Neighbour below (wraps at last row) |
| nbLeft | output | DW | Left neighbour or 0 |
| nbRight | output | DW | Right neighbour or 0 |
| nbMask | output | 4 | Valid neighbours: bit0 up, bit1 down, bit2 left, bit3 right |
| pointCase | output | 4 | Edge/corner class of the centre point |
| resValid | input | 1 | Kernel result present, in tuple order |
| resData | input | DW | Kernel result value |

## Verification
The bench builds the block with its defaults: an 11×11 grid of 16-bit values. All nine point classes therefore occur in every pass, and a full-scale 0xFFFF value can sit next to the wrap rows. It runs one warm-up pass and four computed passes. Each computed pass streams the previous pass's bench-computed averages, so the static rows are checked after several bank swaps. One pass runs with no stalls on either side. One withholds the last result for several cycles while the next pass's input waits.

// File: rtl/stencil_pkg.sv
package stencil_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic shift;    // advance the stream window
    logic pfWrite;  // prefetch write into active static bank
    logic wbWrite;  // write-back into shadow static bank
    logic wrTop;    // write targets the top-row cache (else bottom)
    logic swap;     // exchange active and shadow banks
  } dpStrobe_t;

  typedef enum logic [1:0] {G_IDLE, G_RUN, G_DRAIN, G_DONE} gState_t;

  typedef enum logic [3:0] {
    PC_INNER = 4'd0, PC_TOP = 4'd1, PC_BOT = 4'd2, PC_LEFT = 4'd3,
    PC_RIGHT = 4'd4, PC_TL = 4'd5, PC_TR = 4'd6, PC_BL = 4'd7, PC_BR = 4'd8
  } ptCase_t;

endpackage

// File: rtl/stencil_ctrl.sv
module stencil_ctrl
  import stencil_pkg::*;
#(
  parameter int ROWS = 11,
  parameter int COLS = 11,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inValid,
  output logic          inReady,
  output logic          outValid,
  input  logic          outReady,
  input  logic          resValid,
  output dpStrobe_t     strobe,
  output logic [RW-1:0] cRow,
  output logic [CW-1:0] cCol,
  output logic [CW-1:0] wrCol
);

  localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);
  localparam logic [CW-1:0] LAST_COL = CW'(COLS - 1);

  // prefetch machine
  logic          pfBusy;
  logic [RW-1:0] pfRow;
  logic [CW-1:0] pfCol;
  // gather machine
  gState_t       gState;
  logic [RW-1:0] inRow;
  logic [CW-1:0] inCol;
  // write-back machine
  logic          wbBusy;
  logic [RW-1:0] wRow;
  logic [CW-1:0] wCol;

  logic pfAcc, gAcc, wbAcc, emit, filling, passEnd;

  always_comb begin
    filling  = (inRow == '0);
    pfAcc    = pfBusy && inValid;
    inReady  = pfBusy || (gState == G_RUN && (filling || outReady));
    outValid = (gState == G_RUN && inValid && !filling) || (gState == G_DRAIN);
    gAcc     = (gState == G_RUN) && inValid && inReady;
    emit     = outValid && outReady;
    wbAcc    = wbBusy && !pfBusy && resValid;
    passEnd  = (gState == G_DONE) && !wbBusy;

    strobe.shift   = gAcc || (gState == G_DRAIN && emit);
    strobe.pfWrite = pfAcc && (pfRow == '0 || pfRow == LAST_ROW);
    strobe.wbWrite = wbAcc && (wRow == '0 || wRow == LAST_ROW);
    strobe.wrTop   = pfAcc ? (pfRow == '0) : (wRow == '0);
    strobe.swap    = passEnd;
    wrCol          = pfAcc ? pfCol : wCol;
  end

  // prefetch: one warm-up pass
  always_ff @(posedge clk) begin
    if (rst) begin
      pfBusy <= 1'b1;
      pfRow  <= '0;
      pfCol  <= '0;
    end else if (pfAcc) begin
      if (pfCol == LAST_COL) begin
        pfCol <= '0;
        if (pfRow == LAST_ROW) begin
          pfRow  <= '0;
          pfBusy <= 1'b0;
        end else begin
          pfRow <= pfRow + 1'b1;
        end
      end else begin
        pfCol <= pfCol + 1'b1;
      end
    end
  end

  // gather/emit
  always_ff @(posedge clk) begin
    if (rst) begin
      gState <= G_IDLE;
      inRow  <= '0;
      inCol  <= '0;
      cRow   <= '0;
      cCol   <= '0;
    end else begin
      if (gAcc) begin
        if (inCol == LAST_COL) begin
          inCol <= '0;
          inRow <= (inRow == LAST_ROW) ? '0 : inRow + 1'b1;
        end else begin
          inCol <= inCol + 1'b1;
        end
      end
      if (emit) begin
        if (cCol == LAST_COL) begin
          cCol <= '0;
          cRow <= (cRow == LAST_ROW) ? '0 : cRow + 1'b1;
        end else begin
          cCol <= cCol + 1'b1;
        end
      end
      unique case (gState)
        G_IDLE:  if (!pfBusy) gState <= G_RUN;
        G_RUN:   if (gAcc && inRow == LAST_ROW && inCol == LAST_COL) gState <= G_DRAIN;
        G_DRAIN: if (emit && cRow == LAST_ROW && cCol == LAST_COL) gState <= G_DONE;
        G_DONE:  if (passEnd) gState <= G_RUN;
        default: gState <= G_IDLE;
      endcase
    end
  end

  // write-back of kernel results
  always_ff @(posedge clk) begin
    if (rst) begin
      wbBusy <= 1'b1;
      wRow   <= '0;
      wCol   <= '0;
    end else if (passEnd) begin
      wbBusy <= 1'b1;
    end else if (wbAcc) begin
      if (wCol == LAST_COL) begin
        wCol <= '0;
        if (wRow == LAST_ROW) begin
          wRow   <= '0;
          wbBusy <= 1'b0;
        end else begin
          wRow <= wRow + 1'b1;
        end
      end else begin
        wCol <= wCol + 1'b1;
      end
    end
  end

endmodule

// File: rtl/stencil_dpath.sv
module stencil_dpath
  import stencil_pkg::*;
#(
  parameter int ROWS = 11,
  parameter int COLS = 11,
  parameter int DW   = 16,
  localparam int RW  = $clog2(ROWS),
  localparam int CW  = $clog2(COLS),
  localparam int WIN = 2 * COLS
) (
  input  logic          clk,
  input  logic          rst,
  input  dpStrobe_t     strobe,
  input  logic [DW-1:0] inData,
  input  logic [DW-1:0] resData,
  input  logic [RW-1:0] cRow,
  input  logic [CW-1:0] cCol,
  input  logic [CW-1:0] wrCol,
  output logic [DW-1:0] nbUp,
  output logic [DW-1:0] nbDown,
  output logic [DW-1:0] nbLeft,
  output logic [DW-1:0] nbRight,
  output logic [3:0]    nbMask,
  output ptCase_t       pointCase
);

  localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);
  localparam logic [CW-1:0] LAST_COL = CW'(COLS - 1);

  // window: win[j] holds the value accepted j+1 shifts ago
  logic [DW-1:0] win [WIN];
  // static row caches, two banks each
  logic [DW-1:0] rowTop [2][COLS];
  logic [DW-1:0] rowBot [2][COLS];
  logic          actBank;

  always_ff @(posedge clk) begin
    if (strobe.shift) begin
      win[0] <= inData;
      for (int j = 1; j < WIN; j++) win[j] <= win[j-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) actBank <= 1'b0;
    else if (strobe.swap) actBank <= ~actBank;
  end

  always_ff @(posedge clk) begin
    if (strobe.pfWrite) begin
      if (strobe.wrTop) rowTop[actBank][wrCol] <= inData;
      else              rowBot[actBank][wrCol] <= inData;
    end
    if (strobe.wbWrite) begin
      if (strobe.wrTop) rowTop[~actBank][wrCol] <= resData;
      else              rowBot[~actBank][wrCol] <= resData;
    end
  end

  logic isTop, isBot, isLeft, isRight;

  always_comb begin
    isTop   = (cRow == '0);
    isBot   = (cRow == LAST_ROW);
    isLeft  = (cCol == '0);
    isRight = (cCol == LAST_COL);

    nbUp    = isTop   ? rowBot[actBank][cCol] : win[WIN-1];
    nbDown  = isBot   ? rowTop[actBank][cCol] : inData;
    nbLeft  = isLeft  ? '0 : win[COLS];
    nbRight = isRight ? '0 : win[COLS-2];
    nbMask  = {~isRight, ~isLeft, 2'b11};

    if      (isTop && isLeft)  pointCase = PC_TL;
    else if (isTop && isRight) pointCase = PC_TR;
    else if (isBot && isLeft)  pointCase = PC_BL;
    else if (isBot && isRight) pointCase = PC_BR;
    else if (isTop)            pointCase = PC_TOP;
    else if (isBot)            pointCase = PC_BOT;
    else if (isLeft)           pointCase = PC_LEFT;
    else if (isRight)          pointCase = PC_RIGHT;
    else                       pointCase = PC_INNER;
  end

endmodule

// File: rtl/stencil_tuple_asm.sv
module stencil_tuple_asm
  import stencil_pkg::*;
#(
  parameter int ROWS = 11,
  parameter int COLS = 11,
  parameter int DW   = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inValid,
  input  logic [DW-1:0] inData,
  output logic          inReady,
  output logic          outValid,
  input  logic          outReady,
  output logic [DW-1:0] nbUp,
  output logic [DW-1:0] nbDown,
  output logic [DW-1:0] nbLeft,
  output logic [DW-1:0] nbRight,
  output logic [3:0]    nbMask,
  output logic [3:0]    pointCase,
  input  logic          resValid,
  input  logic [DW-1:0] resData
);

  localparam int RW = $clog2(ROWS);
  localparam int CW = $clog2(COLS);

  dpStrobe_t     strobe;
  logic [RW-1:0] cRow;
  logic [CW-1:0] cCol;
  logic [CW-1:0] wrCol;
  ptCase_t       caseCode;

  stencil_ctrl #(.ROWS(ROWS), .COLS(COLS)) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .outValid(outValid), .outReady(outReady), .resValid(resValid),
    .strobe(strobe), .cRow(cRow), .cCol(cCol), .wrCol(wrCol)
  );

  stencil_dpath #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) u_dpath (
    .clk(clk), .rst(rst), .strobe(strobe), .inData(inData), .resData(resData),
    .cRow(cRow), .cCol(cCol), .wrCol(wrCol),
    .nbUp(nbUp), .nbDown(nbDown), .nbLeft(nbLeft), .nbRight(nbRight),
    .nbMask(nbMask), .pointCase(caseCode)
  );

  assign pointCase = caseCode;

endmodule

// File: rtl/stencil_tuple_chk.sv
module stencil_tuple_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          inReady,
  input logic          outValid,
  input logic          outReady,
  input logic [DW-1:0] nbUp,
  input logic [DW-1:0] nbLeft,
  input logic [DW-1:0] nbRight,
  input logic [3:0]    nbMask,
  input logic [3:0]    pointCase
);

  assert_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !outValid);

  assert_block_R9: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |-> !inReady);

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (!outValid ||
      ($stable(nbUp) && $stable(nbLeft) && $stable(nbRight) && $stable(pointCase))));

  assert_vert_R7: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (nbMask[1:0] == 2'b11));

  assert_left_R7: assert property (@(posedge clk) disable iff (rst)
    (outValid && !nbMask[2]) |-> (nbLeft == '0));

  assert_right_R7: assert property (@(posedge clk) disable iff (rst)
    (outValid && !nbMask[3]) |-> (nbRight == '0));

  assert_range_R8: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (pointCase <= 4'd8));

  assert_inner_R8: assert property (@(posedge clk) disable iff (rst)
    (outValid && pointCase == 4'd0) |-> (nbMask == 4'hF));

endmodule

bind stencil_tuple_asm stencil_tuple_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .inReady(inReady), .outValid(outValid),
  .outReady(outReady), .nbUp(nbUp), .nbLeft(nbLeft), .nbRight(nbRight),
  .nbMask(nbMask), .pointCase(pointCase)
);

// File: tb/stencil_tuple_asm_bench.sv
module stencil_tuple_asm_bench;

  localparam int ROWS = 11;
  localparam int COLS = 11;
  localparam int DW   = 16;
  localparam int NPTS = ROWS * COLS;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          inValid = 1'b0;
  logic [DW-1:0] inData = '0;
  logic          inReady;
  logic          outValid;
  logic          outReady = 1'b0;
  logic [DW-1:0] nbUp, nbDown, nbLeft, nbRight;
  logic [3:0]    nbMask, pointCase;
  logic          resValid = 1'b0;
  logic [DW-1:0] resData = '0;

  always #2 clk = ~clk;

  stencil_tuple_asm #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) u_stencil_tuple_asm (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData), .inReady(inReady),
    .outValid(outValid), .outReady(outReady), .nbUp(nbUp), .nbDown(nbDown),
    .nbLeft(nbLeft), .nbRight(nbRight), .nbMask(nbMask), .pointCase(pointCase),
    .resValid(resValid), .resData(resData)
  );

  int nChk = 0;
  int nFail = 0;
  int grid [ROWS][COLS];
  int nextG [ROWS][COLS];
  int heldRes;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
  endtask

  function automatic int expCase(input int r, input int c);
    bit t = (r == 0), b = (r == ROWS-1), l = (c == 0), rr = (c == COLS-1);
    if (t && l)  return 5;
    if (t && rr) return 6;
    if (b && l)  return 7;
    if (b && rr) return 8;
    if (t)       return 1;
    if (b)       return 2;
    if (l)       return 3;
    if (rr)      return 4;
    return 0;
  endfunction

  function automatic int expUp(input int r, input int c);
    return (r == 0) ? grid[ROWS-1][c] : grid[r-1][c];
  endfunction
  function automatic int expDown(input int r, input int c);
    return (r == ROWS-1) ? grid[0][c] : grid[r+1][c];
  endfunction
  function automatic int expLeft(input int r, input int c);
    return (c == 0) ? 0 : grid[r][c-1];
  endfunction
  function automatic int expRight(input int r, input int c);
    return (c == COLS-1) ? 0 : grid[r][c+1];
  endfunction
  function automatic int expMask(input int c);
    return 3 | ((c != 0) ? 4 : 0) | ((c != COLS-1) ? 8 : 0);
  endfunction
  function automatic int kernelAvg(input int r, input int c);
    int s = expUp(r, c) + expDown(r, c) + expLeft(r, c) + expRight(r, c);
    int n = 2 + ((c != 0) ? 1 : 0) + ((c != COLS-1) ? 1 : 0);
    return s / n;
  endfunction

  // one pass: warm=1 for the prefetch pass; stall=1 for random backpressure
  task automatic runPass(input int pass, input bit warm, input bit stall, input bit holdLast);
    int sent = 0;
    int got = 0;
    bit prevStall = 1'b0;
    bit sawTuple = 1'b0;
    int sUp = 0, sLeft = 0, sRight = 0, sCase = 0;
    while (sent < NPTS || (!warm && got < NPTS)) begin
      @(negedge clk);
      resValid = 1'b0;
      if (sent < NPTS) begin
        inValid = prevStall ? 1'b1 : (stall ? (($urandom % 4) != 0) : 1'b1);
        inData  = DW'(grid[sent / COLS][sent % COLS]);
      end else begin
        inValid = 1'b0;
      end
      outReady = stall ? (($urandom % 3) != 0) : 1'b1;
      #1;
      if (prevStall) begin
        check(outValid, "R9", "tuple withdrawn under stall", int'(outValid), 1);
        check(int'(nbUp) == sUp && int'(nbLeft) == sLeft && int'(nbRight) == sRight &&
              int'(pointCase) == sCase, "R9", "tuple changed under stall", int'(nbUp), sUp);
      end
      prevStall = 1'b0;
      if (warm) begin
        if (outValid) sawTuple = 1'b1;
      end else if (outValid && !outReady) begin
        check(!inReady, "R9", "input accepted while stalled", int'(inReady), 0);
        prevStall = 1'b1;
        sUp = int'(nbUp); sLeft = int'(nbLeft); sRight = int'(nbRight); sCase = int'(pointCase);
      end else if (outValid && outReady) begin
        int r = got / COLS;
        int c = got % COLS;
        string vreq = (r == 0) ? ((pass > 1) ? "R10" : "R5") :
                      (r == ROWS-1) ? ((pass > 1) ? "R10" : "R6") : "R4";
        check(got < NPTS, "R3", "extra tuple", got, NPTS - 1);
        check(int'(pointCase) == expCase(r, c), "R8", "point class", int'(pointCase), expCase(r, c));
        check(int'(nbMask) == expMask(c), "R7", "mask", int'(nbMask), expMask(c));
        check(int'(nbUp) == expUp(r, c), vreq, "up neighbour", int'(nbUp), expUp(r, c));
        check(int'(nbDown) == expDown(r, c), vreq, "down neighbour", int'(nbDown), expDown(r, c));
        check(int'(nbLeft) == expLeft(r, c), "R7", "left neighbour", int'(nbLeft), expLeft(r, c));
        check(int'(nbRight) == expRight(r, c), "R7", "right neighbour", int'(nbRight), expRight(r, c));
        nextG[r][c] = kernelAvg(r, c);
        if (holdLast && got == NPTS-1) begin
          heldRes = nextG[r][c];
        end else begin
          resValid = 1'b1;
          resData  = DW'(nextG[r][c]);
        end
        got++;
      end
      if (inValid && inReady) sent++;
    end
    if (warm) check(!sawTuple, "R2", "tuple during warm-up", int'(sawTuple), 0);
    else      check(got == NPTS, "R3", "tuples per pass", got, NPTS);
  endtask

  initial begin
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        grid[r][c] = int'($urandom(32'd7321) % 65536);
    grid[0][5] = 65535; grid[ROWS-1][5] = 65535; grid[5][0] = 65535; grid[5][COLS-1] = 65535;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(!outValid, "R1", "outValid after reset", int'(outValid), 0);
    check(inReady, "R1", "inReady after reset", int'(inReady), 1);

    runPass(0, 1'b1, 1'b1, 1'b0);                 // warm-up fills static rows
    runPass(1, 1'b0, 1'b0, 1'b0);                 // no stalls
    for (int r = 0; r < ROWS; r++) for (int c = 0; c < COLS; c++) grid[r][c] = nextG[r][c];
    runPass(2, 1'b0, 1'b1, 1'b1);                 // last result withheld
    // R11: next pass must wait for the missing result
    @(negedge clk);
    resValid = 1'b0;
    inValid  = 1'b1;
    inData   = DW'(nextG[0][0]);
    for (int k = 0; k < 5; k++) begin
      #1;
      check(!inReady, "R11", "next pass accepted early", int'(inReady), 0);
      @(negedge clk);
    end
    inValid  = 1'b0;
    resValid = 1'b1;
    resData  = DW'(heldRes);
    @(negedge clk);
    resValid = 1'b0;
    for (int r = 0; r < ROWS; r++) for (int c = 0; c < COLS; c++) grid[r][c] = nextG[r][c];
    runPass(3, 1'b0, 1'b1, 1'b0);
    for (int r = 0; r < ROWS; r++) for (int c = 0; c < COLS; c++) grid[r][c] = nextG[r][c];
    runPass(4, 1'b0, 1'b1, 1'b0);

    finished = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL R3 watchdog: actual hung expected pass completion");
      report();
      $finish;
    end
  end

endmodule